// File: doc/BRIEF.md
# Dual-Channel Compare-Match Timer

Two independent 16-bit up-counters share one small register port. Each channel divides the common clock by 8, 32, 128 or 512 and advances its counter once per division period while its start bit is set. When a running counter equals the channel's compare value at a division boundary, the counter returns to zero instead of incrementing. If the channel's interrupt enable is set, a pulse one clock wide then appears on that channel's interrupt line.

Software uses one common start register. Each channel also has its own control, counter and compare registers. Counter and compare can be rewritten at any moment, running or not, and counting carries on from whatever was written. Reads have one cycle of latency. Halfword slots that hold no register read as all ones and ignore writes.

Top module: `dual_match_timer`

## Requirements
- R1: Registers are selected by address bits 3:1, and bit 0 is ignored. Slot 0 is the common start register. Slots 1, 2 and 3 are channel 0's control, counter and compare registers. Slots 4, 5 and 6 are the same three registers for channel 1.
- R2: Start bit 0 runs channel 0 and start bit 1 runs channel 1. A read of the start register returns those two bits, and bits 15:2 read as zero.
- R3: Control bits 1:0 select the divide ratio: 0 gives /8, 1 gives /32, 2 gives /128 and 3 gives /512. A running counter advances by one per completed period of the selected ratio.
- R4: Control bit 6 is the interrupt enable. The other control bits are dropped on write and read as zero, so writing 0xFFFF reads back as 0x0043.
- R5: Suppose a division boundary arrives while the channel runs and its counter equals its compare value. The counter then becomes zero. If the enable is set, the interrupt output is high for exactly the next cycle.
- R6: After reset, start and both control registers read 0, both counters read 0, both compare registers read 0xFFFF, and rdata is 0.
- R7: Counter and compare writes take effect at any time, including while the channel runs, and counting continues from the written values.
- R8: Clearing a start bit freezes that counter. Setting the bit again resumes counting from the frozen value. The division phase restarts on the 0-to-1 change, so the first increment comes one full period after the start write.
- R9: Slot 7 (byte addresses 14 and 15) reads as 0xFFFF, and writes to it change nothing.
- R10: A counter write in the same cycle as an increment or a match wins: the written value is stored and no interrupt results from that cycle.
- R11: rdata takes the selected register's value on the clock edge where rd_en is sampled high. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock, also the prescaler input |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the slot at addr |
| rd_en | input | 1 | Read strobe; rdata updates on this edge |
| addr | input | 4 | Byte address; bit 0 ignored |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, registered |
| irq | output | 2 | Per-channel compare-match interrupt pulses |

## Verification
The properties assume that addr and wdata hold known values whenever a strobe is high. They also assume that reset is applied before the first strobe. The bench meets both by driving every input from tasks at the falling edge and by holding reset low for several cycles at the start. Random writes keep compare and counter values small, so matches, clears and write-versus-increment collisions happen often without long waits. A cycle-level reference model in the bench predicts rdata and both interrupt lines on every cycle.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
    localparam int NUM_CH  = 2;
    localparam int CKS_W   = 2;
    localparam int IE_BIT  = 6;
    localparam int SLOT_W  = 3;
    localparam int ADDR_W  = SLOT_W + 1;

    localparam logic [SLOT_W-1:0] SLOT_START = 3'd0;
    localparam logic [SLOT_W-1:0] SLOT_HOLE  = 3'd7;

    typedef enum logic [1:0] {
        REG_CTL = 2'd0,
        REG_CNT = 2'd1,
        REG_CMP = 2'd2
    } chreg_e;

    // channel i occupies three consecutive slots after the start slot
    function automatic logic [SLOT_W-1:0] slot_of(int ch, chreg_e r);
        return SLOT_W'(1 + 3 * ch + int'(r));
    endfunction
endpackage

// File: rtl/dmt_prescaler.sv
module dmt_prescaler #(
    parameter int CKS_W    = 2,
    parameter int BASE_LOG = 3,
    parameter int STEP_LOG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [CKS_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int PRE_W = BASE_LOG + STEP_LOG * ((1 << CKS_W) - 1);

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] mask;

    always_comb begin
        span   = (PRE_W + 1)'(1) << (BASE_LOG + STEP_LOG * int'(sel_i));
        mask   = PRE_W'(span - 1'b1);
        tick_o = (pre_q & mask) == mask;
        pre_d  = restart_i ? '0 : pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R8: phase restarts on a start rising edge
    a_r8_phase_reset: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> pre_q == '0);
endmodule

// File: rtl/dmt_channel.sv
module dmt_channel #(
    parameter int W      = 16,
    parameter int CKS_W  = 2,
    parameter int IE_BIT = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         restart_i,
    input  logic         wr_ctl_i,
    input  logic         wr_cnt_i,
    input  logic         wr_cmp_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] ctl_o,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cmp_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [CKS_W-1:0] cks;
        logic             ie;
        logic [W-1:0]     cnt;
        logic [W-1:0]     cmp;
        logic             irq;
    } ch_t;

    ch_t  d, q;
    logic tick;
    logic match;

    dmt_prescaler #(.CKS_W(CKS_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart_i),
        .sel_i     (q.cks),
        .tick_o    (tick)
    );

    always_comb begin
        d     = q;
        match = run_i && tick && (q.cnt == q.cmp) && !wr_cnt_i;
        d.irq = match && q.ie;
        if (wr_ctl_i) begin
            d.cks = wdata_i[CKS_W-1:0];
            d.ie  = wdata_i[IE_BIT];
        end
        if (wr_cmp_i) d.cmp = wdata_i;
        if (wr_cnt_i)              d.cnt = wdata_i;
        else if (run_i && tick)    d.cnt = match ? '0 : q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.cmp <= '1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        ctl_o                = '0;
        ctl_o[CKS_W-1:0]     = q.cks;
        ctl_o[IE_BIT]        = q.ie;
    end
    assign cnt_o = q.cnt;
    assign cmp_o = q.cmp;
    assign irq_o = q.irq;

    // R5: pulse lasts one cycle
    a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq |=> !q.irq);
    // R5: pulse only with enable, and counter is cleared when it appears
    a_r5_pulse_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq |-> $past(q.ie) && q.cnt == '0);
    // R8: stopped counter holds unless software writes it
    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wr_cnt_i) |=> q.cnt == $past(q.cnt));
    // R10: software write wins over increment and clear
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_i |=> q.cnt == $past(wdata_i) && !q.irq);
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
    import dmt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    output logic [NUM_CH-1:0] irq
);
    typedef struct packed {
        logic [NUM_CH-1:0] run;
        logic [W-1:0]      rdata;
    } top_t;

    top_t              d, q;
    logic [SLOT_W-1:0] slot;
    logic              unused_addr_lsb;
    logic              wr_start;
    logic [NUM_CH-1:0] restart;
    logic [W-1:0]      ch_ctl [NUM_CH];
    logic [W-1:0]      ch_cnt [NUM_CH];
    logic [W-1:0]      ch_cmp [NUM_CH];
    logic [W-1:0]      rd_val;

    assign slot            = addr[ADDR_W-1:1];
    assign unused_addr_lsb = addr[0];
    assign wr_start        = wr_en && (slot == SLOT_START);
    assign restart         = wr_start ? (wdata[NUM_CH-1:0] & ~q.run) : '0;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        dmt_channel #(.W(W), .CKS_W(CKS_W), .IE_BIT(IE_BIT)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_i     (q.run[i]),
            .restart_i (restart[i]),
            .wr_ctl_i  (wr_en && slot == slot_of(i, REG_CTL)),
            .wr_cnt_i  (wr_en && slot == slot_of(i, REG_CNT)),
            .wr_cmp_i  (wr_en && slot == slot_of(i, REG_CMP)),
            .wdata_i   (wdata),
            .ctl_o     (ch_ctl[i]),
            .cnt_o     (ch_cnt[i]),
            .cmp_o     (ch_cmp[i]),
            .irq_o     (irq[i])
        );
    end

    always_comb begin
        rd_val = '1;
        if (slot == SLOT_START) rd_val = {{(W - NUM_CH){1'b0}}, q.run};
        for (int i = 0; i < NUM_CH; i++) begin
            if (slot == slot_of(i, REG_CTL)) rd_val = ch_ctl[i];
            if (slot == slot_of(i, REG_CNT)) rd_val = ch_cnt[i];
            if (slot == slot_of(i, REG_CMP)) rd_val = ch_cmp[i];
        end
    end

    always_comb begin
        d       = q;
        if (wr_start) d.run = wdata[NUM_CH-1:0];
        if (rd_en)    d.rdata = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata = q.rdata;

    // R9: hole slot reads all ones
    a_r9_hole_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && slot == SLOT_HOLE) |=> rdata == '1);
    // R2: start readback has only the run bits
    a_r2_start_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && slot == SLOT_START) |=> rdata[W-1:NUM_CH] == '0);
    // R11: read data holds between reads
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/dual_match_timer_tb.sv
module dual_match_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    dual_match_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // reference model state
    logic [1:0]  m_run;
    logic [8:0]  m_pre [2];
    logic [15:0] m_cnt [2];
    logic [15:0] m_cmp [2];
    logic [1:0]  m_cks [2];
    logic        m_ie  [2];
    logic [1:0]  m_irq;
    logic [15:0] m_rdata;
    logic [2:0]  last_slot = 3'd0;

    function automatic logic [15:0] model_read(logic [2:0] s);
        case (s)
            3'd0: return {14'd0, m_run};
            3'd1: return {9'd0, m_ie[0], 4'd0, m_cks[0]};
            3'd2: return m_cnt[0];
            3'd3: return m_cmp[0];
            3'd4: return {9'd0, m_ie[1], 4'd0, m_cks[1]};
            3'd5: return m_cnt[1];
            3'd6: return m_cmp[1];
            default: return 16'hFFFF;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] s);
        case (s)
            3'd0: return "R2";
            3'd1, 3'd4: return "R4";
            3'd7: return "R9";
            default: return "R7";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = '0; m_irq = '0; m_rdata = '0;
            for (int i = 0; i < 2; i++) begin
                m_pre[i] = '0; m_cnt[i] = '0; m_cmp[i] = 16'hFFFF;
                m_cks[i] = '0; m_ie[i] = 1'b0;
            end
        end else begin
            automatic logic [2:0] s = addr[3:1];
            if (rd_en) begin
                m_rdata = model_read(s);
                last_slot = s;
            end
            for (int i = 0; i < 2; i++) begin
                automatic logic [9:0] sp = 10'd1 << (3 + 2 * int'(m_cks[i]));
                automatic logic [8:0] mk = 9'(sp - 10'd1);
                automatic logic tk = (m_pre[i] & mk) == mk;
                automatic logic wc = wr_en && s == 3'(3 * i + 2);
                automatic logic eq = m_cnt[i] == m_cmp[i];
                automatic logic rs = wr_en && s == 3'd0 && wdata[i] && !m_run[i];
                m_irq[i] = m_run[i] && tk && eq && !wc && m_ie[i];
                if (wc) m_cnt[i] = wdata;
                else if (m_run[i] && tk) m_cnt[i] = eq ? 16'd0 : m_cnt[i] + 16'd1;
                m_pre[i] = rs ? 9'd0 : m_pre[i] + 9'd1;
                if (wr_en && s == 3'(3 * i + 1)) begin
                    m_cks[i] = wdata[1:0];
                    m_ie[i]  = wdata[6];
                end
                if (wr_en && s == 3'(3 * i + 3)) m_cmp[i] = wdata;
            end
            if (wr_en && s == 3'd0) m_run = wdata[1:0];
        end
    end

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model (R5 interrupts, R11 read data)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5", {14'd0, irq}, {14'd0, m_irq});
            chk(tag_of(last_slot), rdata, m_rdata);
        end
    end

    task automatic wr(logic [3:0] a, logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic rd_exp(logic [3:0] a, logic [15:0] exp, string tag);
        logic [15:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        int pulses;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        chk("R6", rdata, 16'h0000);
        rst_n = 1'b1;

        // R6 reset values
        rd_exp(4'd0,  16'h0000, "R6");
        rd_exp(4'd2,  16'h0000, "R6");
        rd_exp(4'd4,  16'h0000, "R6");
        rd_exp(4'd6,  16'hFFFF, "R6");
        rd_exp(4'd8,  16'h0000, "R6");
        rd_exp(4'd10, 16'h0000, "R6");
        rd_exp(4'd13, 16'hFFFF, "R6");

        // R1 channel separation, odd address bit ignored; R4 masking
        wr(4'd3, 16'h0001);
        wr(4'd8, 16'h0042);
        rd_exp(4'd2, 16'h0001, "R1");
        rd_exp(4'd9, 16'h0042, "R1");
        wr(4'd2, 16'hFFFF);
        rd_exp(4'd2, 16'h0043, "R4");
        wr(4'd2, 16'h0000);
        wr(4'd0, 16'hFFFC);
        rd_exp(4'd0, 16'h0000, "R2");

        // R3 divide by 128 on channel 1, then R8 freeze
        wr(4'd8, 16'h0002);
        wr(4'd0, 16'h0002);
        repeat (640) @(negedge clk);
        wr(4'd0, 16'h0000);
        rd_exp(4'd10, 16'd5, "R3");
        repeat (300) @(negedge clk);
        rd_exp(4'd10, 16'd5, "R8");

        // R5 match every third /8 period with enable
        wr(4'd2, 16'h0040);
        wr(4'd6, 16'd2);
        wr(4'd0, 16'h0001);
        pulses = 0;
        repeat (240) begin
            @(negedge clk);
            if (irq[0]) pulses++;
        end
        chk("R5", 16'(pulses), 16'd10);
        wr(4'd0, 16'h0000);

        // R10 continuous counter writes suppress every match
        wr(4'd6, 16'd0);
        wr(4'd4, 16'd5);
        wr(4'd0, 16'h0001);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'd4; wdata = 16'd0;
        pulses = 0;
        repeat (64) begin
            @(negedge clk);
            if (irq[0]) pulses++;
        end
        wr_en = 1'b0;
        chk("R10", 16'(pulses), 16'd0);
        wr(4'd0, 16'h0000);

        // R9 hole slot
        wr(4'd14, 16'h1234);
        rd_exp(4'd15, 16'hFFFF, "R9");
        rd_exp(4'd6, 16'h0000, "R9");

        // random mix, checked cycle by cycle against the model
        for (int k = 0; k < 3000; k++) begin
            automatic int op = $urandom_range(0, 9);
            automatic logic [3:0] a = 4'($urandom_range(0, 15));
            if (op < 5) begin
                repeat ($urandom_range(1, 20)) @(negedge clk);
            end else if (op < 7) begin
                logic [15:0] v;
                rd(a, v);
            end else begin
                automatic logic [15:0] v = 16'($urandom);
                if (a[3:1] inside {3'd2, 3'd3, 3'd5, 3'd6}) v = 16'($urandom_range(0, 15));
                wr(a, v);
            end
        end
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule